// File: doc/BRIEF.md
# Capture Compare Output Timer

This block is a free-running up-counter with a register-style control word, meant to sit behind a bus wrapper inside a larger peripheral. Software preloads the counter while it is stopped, sets the start bit and lets it count on the functional clock. The count rate is either one step per cycle or slowed by a power-of-two prescaler. On the step after the all-ones value the counter either wraps to zero or reloads from a load register. It can flag a compare match against a match register, and it can latch the counter into one of two capture registers on chosen edges of an external input pin.

A single output pin is driven from the counter events. Depending on the control word it stays at its default level, gives a one-cycle pulse away from that level, or toggles. The trigger is overflow alone or overflow together with compare match. Three one-cycle event flags (match, overflow, capture) are brought out for an interrupt block elsewhere.

Register map on the 3-bit address: 0 control, 1 counter (read/write), 2 load, 3 match, 4 first capture (read only), 5 second capture (read only). Read data is combinational from the address.

Top module: `ccp_timer_core`

## Requirements
- R1: After reset the control word, counter, load, match and both capture registers read 0, the event flags are 0 and the output pin is 0.
- R2: While control bit 0 is clear the counter holds its value. A write to address 1 loads the counter, and once bit 0 is set it counts up by one per clock, starting from that value.
- R3: With control bit 5 set, the counter advances once every 2^(P+1) clocks, where P is the 3-bit field in control bits 4:2.
- R4: Without auto-reload (control bit 1 clear), the step after all-ones gives 0.
- R5: The step after all-ones raises event flag bit 1 for one cycle. With control bit 1 set, the counter takes the load register value on that step.
- R6: With control bit 6 set, a step that makes the counter equal to the match register raises event flag bit 0 for one cycle, in the cycle the new count is visible. With bit 6 clear no match flag is raised.
- R7: Control bits 9:8 select the capture edge: 01 rising, 10 falling, 11 both. The input passes a two-stage synchronizer. A selected edge copies the counter into the first capture register 3 clocks after the pin changes.
- R8: Each capture in single mode raises event flag bit 2 for one cycle. With bits 9:8 at 00, or on an edge of the unselected polarity, nothing is captured.
- R9: With control bit 13 set, the first selected edge fills capture register 1 with no flag. The second fills capture register 2 and raises event flag bit 2.
- R10: Control bits 11:10 select the output trigger: 0 none, 1 overflow, 2 overflow or compare match. A trigger toggles the pin when control bit 12 is set. Otherwise the pin leaves the default level for exactly one cycle.
- R11: Every control write sets the output pin to the new default level given by control bit 7. Between triggers in pulse mode the pin stays at that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| cap_pin | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Pulse or toggle output |
| evt_flags | output | 3 | One-cycle events: bit 0 match, bit 1 overflow, bit 2 capture |

## Verification
The assertions assume that software writes the match register only while the compare function is idle. They also assume the capture pin stays stable for at least two clocks between edges, so the synchronizer sees every edge. The bench writes the match register only while the counter is stopped. It moves the capture pin on falling clock edges and holds each level for four clocks. Both-edge capture is therefore never fed edges closer together than the synchronizer can resolve.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  localparam int CTL_RUN     = 0;
  localparam int CTL_AR      = 1;
  localparam int CTL_PTV_LO  = 2;
  localparam int CTL_PRE     = 5;
  localparam int CTL_CMP     = 6;
  localparam int CTL_DEF     = 7;
  localparam int CTL_EDGE_LO = 8;
  localparam int CTL_TRIG_LO = 10;
  localparam int CTL_TOG     = 12;
  localparam int CTL_DUAL    = 13;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_LOAD  = 3'd2,
    A_MATCH = 3'd3,
    A_CAP1  = 3'd4,
    A_CAP2  = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    TRG_NONE    = 2'd0,
    TRG_OVF     = 2'd1,
    TRG_OVF_CMP = 2'd2,
    TRG_RSVD    = 2'd3
  } trig_e;

  // Terminal value of the prescaler counter for a 2^(ptv+1) division.
  function automatic int unsigned presc_limit(input int unsigned ptv);
    return (32'd1 << (ptv + 1)) - 32'd1;
  endfunction

  // Edge detect for the capture selector: 01 rise, 10 fall, 11 both.
  function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
    case (sel)
      2'b01:   return !prev && cur;
      2'b10:   return prev && !cur;
      2'b11:   return prev ^ cur;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ccp_prescaler.sv
module ccp_prescaler #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);
  import ccp_pkg::*;

  localparam int DIV_W = 1 << PTV_W;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] limit;
  logic             at_limit;

  assign limit    = DIV_W'(presc_limit(32'(ptv)));
  assign at_limit = (pcnt == limit);
  assign tick     = run && (!pre_en || at_limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                          pcnt <= '0;
    else if (!run || !pre_en || at_limit) pcnt <= '0;
    else                                 pcnt <= pcnt + 1'b1;
  end

  // R3: with the prescaler active, two ticks never come in adjacent cycles
  a_r3_ticks_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_en) |=> !(tick && pre_en && $past(pre_en) && $stable(ptv)));

endmodule

// File: rtl/ccp_capture.sv
module ccp_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  logic [1:0]   sel,
  input  logic         dual,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap1,
  output logic [W-1:0] cap2,
  output logic         cap_evt
);
  import ccp_pkg::*;

  logic [1:0] sync_q;
  logic       prev_q;
  logic       slot_q;
  logic       hit;

  assign hit = edge_hit(sel, prev_q, sync_q[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      slot_q  <= 1'b0;
      cap1    <= '0;
      cap2    <= '0;
      cap_evt <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], pin};
      prev_q  <= sync_q[1];
      cap_evt <= 1'b0;
      if (!dual) slot_q <= 1'b0;
      if (hit) begin
        if (dual && slot_q) begin
          cap2    <= count;
          slot_q  <= 1'b0;
          cap_evt <= 1'b1;
        end else if (dual) begin
          cap1    <= count;
          slot_q  <= 1'b1;
        end else begin
          cap1    <= count;
          cap_evt <= 1'b1;
        end
      end
    end
  end

  // R8: a capture event needs a selected edge polarity
  a_r8_capture_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> $past(sel != 2'b00));

  // R9: in dual mode the event only follows the second stored edge
  a_r9_dual_second_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && $past(dual)) |-> $past(slot_q));

endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       new_def,
  input  logic       def_lvl,
  input  logic       toggle,
  input  logic [1:0] trig_mode,
  input  logic       ovf_hit,
  input  logic       match_hit,
  output logic       pwm
);
  import ccp_pkg::*;

  logic trig;

  always_comb begin
    case (trig_e'(trig_mode))
      TRG_OVF:     trig = ovf_hit;
      TRG_OVF_CMP: trig = ovf_hit || match_hit;
      default:     trig = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pwm <= 1'b0;
    else if (ctrl_wr)  pwm <= new_def;
    else if (trig)     pwm <= toggle ? !pwm : !def_lvl;
    else if (!toggle)  pwm <= def_lvl;
  end

  // R11: in pulse mode with no trigger the pin rests at the default level
  a_r11_pulse_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!toggle && !trig && !ctrl_wr) && !toggle) |-> (pwm == def_lvl));

  // R10: without a trigger or control write a toggling pin keeps its level
  a_r10_toggle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && !trig && !ctrl_wr) |=> $stable(pwm));

endmodule

// File: rtl/ccp_timer_core.sv
module ccp_timer_core #(
  parameter int W     = 32,
  parameter int AW    = 3,
  parameter int PTV_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          cap_pin,
  output logic          pwm_out,
  output logic [2:0]    evt_flags
);
  import ccp_pkg::*;

  logic [W-1:0] ctrl_q, cnt_q, load_q, match_q, cap1, cap2;
  logic [W-1:0] cnt_nxt;
  logic         ctrl_wr, cnt_wr;
  logic         tick, at_max, ovf_hit, match_hit;
  logic         ovf_q, match_evt_q, cap_evt;

  assign ctrl_wr = reg_wr && (reg_addr == AW'(A_CTRL));
  assign cnt_wr  = reg_wr && (reg_addr == AW'(A_COUNT));

  ccp_prescaler #(.PTV_W(PTV_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q[CTL_RUN]),
    .pre_en (ctrl_q[CTL_PRE]),
    .ptv    (ctrl_q[CTL_PTV_LO +: PTV_W]),
    .tick   (tick)
  );

  // Internal event wires
  assign at_max    = &cnt_q;
  assign cnt_nxt   = at_max ? (ctrl_q[CTL_AR] ? load_q : '0) : cnt_q + 1'b1;
  assign ovf_hit   = tick && at_max && !cnt_wr;
  assign match_hit = tick && ctrl_q[CTL_CMP] && !cnt_wr && (cnt_nxt == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      load_q      <= '0;
      match_q     <= '0;
      cnt_q       <= '0;
      ovf_q       <= 1'b0;
      match_evt_q <= 1'b0;
    end else begin
      if (ctrl_wr)                                   ctrl_q  <= reg_wdata;
      if (reg_wr && reg_addr == AW'(A_LOAD))         load_q  <= reg_wdata;
      if (reg_wr && reg_addr == AW'(A_MATCH))        match_q <= reg_wdata;
      if (cnt_wr)    cnt_q <= reg_wdata;
      else if (tick) cnt_q <= cnt_nxt;
      ovf_q       <= ovf_hit;
      match_evt_q <= match_hit;
    end
  end

  ccp_capture #(.W(W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (cap_pin),
    .sel     (ctrl_q[CTL_EDGE_LO +: 2]),
    .dual    (ctrl_q[CTL_DUAL]),
    .count   (cnt_q),
    .cap1    (cap1),
    .cap2    (cap2),
    .cap_evt (cap_evt)
  );

  ccp_pwm u_pwm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .new_def   (reg_wdata[CTL_DEF]),
    .def_lvl   (ctrl_q[CTL_DEF]),
    .toggle    (ctrl_q[CTL_TOG]),
    .trig_mode (ctrl_q[CTL_TRIG_LO +: 2]),
    .ovf_hit   (ovf_hit),
    .match_hit (match_hit),
    .pwm       (pwm_out)
  );

  assign evt_flags = {cap_evt, ovf_q, match_evt_q};

  always_comb begin
    case (reg_addr)
      AW'(A_CTRL):  reg_rdata = ctrl_q;
      AW'(A_COUNT): reg_rdata = cnt_q;
      AW'(A_LOAD):  reg_rdata = load_q;
      AW'(A_MATCH): reg_rdata = match_q;
      AW'(A_CAP1):  reg_rdata = cap1;
      AW'(A_CAP2):  reg_rdata = cap2;
      default:      reg_rdata = '0;
    endcase
  end

  // R2: a stopped counter only changes through a register write
  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTL_RUN] && !cnt_wr) |=> $stable(cnt_q));

  // R5: the overflow flag follows a cycle in which the counter was all ones
  a_r5_ovf_from_max: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(&cnt_q));

  // R4: without auto-reload an overflow leaves the counter at zero
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !$past(ctrl_q[CTL_AR])) |-> (cnt_q == '0));

  // R6: a match flag needs compare enabled in the cycle before
  a_r6_match_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt_q |-> $past(ctrl_q[CTL_CMP]));

endmodule

// File: tb/tb_ccp_timer_core.sv
module tb_ccp_timer_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cap_pin = 1'b0;
  logic        pwm_out;
  logic [2:0]  evt_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccp_timer_core dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_pin(cap_pin),
    .pwm_out(pwm_out), .evt_flags(evt_flags)
  );

  // Control bit helpers
  localparam logic [31:0] RUN = 32'h1, AR = 32'h2, PRE = 32'h20, CMP = 32'h40;
  localparam logic [31:0] DEF = 32'h80, TOG = 32'h1000, DUAL = 32'h2000;
  function automatic logic [31:0] psel(input int p); return 32'(p) << 2; endfunction
  function automatic logic [31:0] esel(input int e); return 32'(e) << 8; endfunction
  function automatic logic [31:0] tsel(input int t); return 32'(t) << 10; endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1", $sformatf("reg %0d after reset", a), v, 32'h0);
    end
    chk("R1", "flags after reset", 32'(evt_flags), 32'h0);
    chk("R1", "pin after reset", 32'(pwm_out), 32'h0);
  endtask

  task automatic t_start_and_hold;
    logic [31:0] v, held;
    wr(1, 32'h1000);
    wait_n(4);
    rd(1, v);
    chk("R2", "preload held while stopped", v, 32'h1000);
    wr(0, RUN);
    wait_n(5);
    rd(1, v);
    chk("R2", "count after 5 cycles", v, 32'h1005);
    wr(0, 32'h0);
    rd(1, held);
    wait_n(5);
    rd(1, v);
    chk("R2", "count frozen after stop", v, held);
  endtask

  task automatic t_prescaler;
    logic [31:0] v;
    wr(1, 32'h0);
    wr(0, RUN | PRE | psel(1));
    wait_n(3);
    rd(1, v); chk("R3", "div4 before first step", v, 32'h0);
    wait_n(1);
    rd(1, v); chk("R3", "div4 first step", v, 32'h1);
    wait_n(4);
    rd(1, v); chk("R3", "div4 second step", v, 32'h2);
    wr(0, 32'h0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFE);
    wr(0, RUN);
    wait_n(2);
    rd(1, v); chk("R4", "wrap to zero", v, 32'h0);
    chk("R5", "overflow flag on wrap", 32'(evt_flags[1]), 32'h1);
    wait_n(1);
    rd(1, v); chk("R4", "counts on from zero", v, 32'h1);
    wr(0, 32'h0);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(2, 32'h100);
    wr(1, 32'hFFFF_FFFD);
    wr(0, RUN | AR);
    wait_n(2);
    chk("R5", "no overflow before max", 32'(evt_flags[1]), 32'h0);
    wait_n(1);
    rd(1, v); chk("R5", "reloaded value", v, 32'h100);
    chk("R5", "overflow flag set", 32'(evt_flags[1]), 32'h1);
    wait_n(1);
    chk("R5", "overflow flag one cycle", 32'(evt_flags[1]), 32'h0);
    wr(0, 32'h0);
  endtask

  task automatic t_match;
    wr(3, 32'd13);
    wr(1, 32'd10);
    wr(0, RUN | CMP);
    wait_n(2);
    chk("R6", "no match early", 32'(evt_flags[0]), 32'h0);
    wait_n(1);
    chk("R6", "match flag", 32'(evt_flags[0]), 32'h1);
    wait_n(1);
    chk("R6", "match flag one cycle", 32'(evt_flags[0]), 32'h0);
    wr(0, 32'h0);
    wr(1, 32'd10);
    wr(0, RUN);
    wait_n(3);
    chk("R6", "no match with compare off", 32'(evt_flags[0]), 32'h0);
    wr(0, 32'h0);
  endtask

  task automatic t_capture_single;
    logic [31:0] v;
    wr(1, 32'h55);
    wr(0, esel(1));
    cap_pin = 1'b1;
    wait_n(2);
    chk("R7", "no capture before sync", 32'(evt_flags[2]), 32'h0);
    wait_n(1);
    chk("R8", "capture flag", 32'(evt_flags[2]), 32'h1);
    wait_n(1);
    chk("R8", "capture flag one cycle", 32'(evt_flags[2]), 32'h0);
    rd(4, v); chk("R7", "rising capture value", v, 32'h55);
    wr(1, 32'h66);
    cap_pin = 1'b0;
    wait_n(4);
    rd(4, v); chk("R7", "falling edge ignored on rising select", v, 32'h55);
    wr(0, esel(2));
    cap_pin = 1'b1; wait_n(4);
    rd(4, v); chk("R7", "rising ignored on falling select", v, 32'h55);
    cap_pin = 1'b0; wait_n(4);
    rd(4, v); chk("R7", "falling capture", v, 32'h66);
    wr(0, esel(0));
    wr(1, 32'h77);
    cap_pin = 1'b1; wait_n(4);
    rd(4, v); chk("R8", "select 00 captures nothing", v, 32'h66);
    wr(0, esel(3));
    cap_pin = 1'b0; wait_n(4);
    rd(4, v); chk("R7", "both edges falling", v, 32'h77);
    wr(1, 32'h88);
    cap_pin = 1'b1; wait_n(4);
    rd(4, v); chk("R7", "both edges rising", v, 32'h88);
    cap_pin = 1'b0; wait_n(4);
  endtask

  task automatic t_capture_dual;
    logic [31:0] v;
    int flags = 0;
    wr(0, 32'h0);
    wr(1, 32'hA1);
    wr(0, esel(1) | DUAL);
    cap_pin = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); flags += int'(evt_flags[2]); end
    cap_pin = 1'b0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); flags += int'(evt_flags[2]); end
    chk("R9", "no flag after first edge", 32'(flags), 32'h0);
    rd(4, v); chk("R9", "first edge to capture 1", v, 32'hA1);
    wr(1, 32'hB2);
    cap_pin = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); flags += int'(evt_flags[2]); end
    chk("R9", "one flag after second edge", 32'(flags), 32'h1);
    rd(5, v); chk("R9", "second edge to capture 2", v, 32'hB2);
    rd(4, v); chk("R9", "capture 1 kept", v, 32'hA1);
    cap_pin = 1'b0; wait_n(4);
    wr(0, 32'h0);
  endtask

  task automatic t_out_toggle_ovf;
    wr(2, 32'hFFFF_FFFE);
    wr(1, 32'hFFFF_FFFE);
    wr(0, RUN | AR | tsel(1) | TOG);
    chk("R11", "default level after write", 32'(pwm_out), 32'h0);
    wait_n(2);
    chk("R10", "toggle on overflow", 32'(pwm_out), 32'h1);
    wait_n(1);
    chk("R10", "toggle held", 32'(pwm_out), 32'h1);
    wait_n(1);
    chk("R10", "toggle back", 32'(pwm_out), 32'h0);
    wr(0, 32'h0);
  endtask

  task automatic t_out_pulse;
    wr(1, 32'hFFFF_FFFE);
    wr(0, RUN | AR | DEF | tsel(1));
    chk("R11", "default high after write", 32'(pwm_out), 32'h1);
    wait_n(2);
    chk("R10", "pulse low on overflow", 32'(pwm_out), 32'h0);
    wait_n(1);
    chk("R11", "back to default", 32'(pwm_out), 32'h1);
    wr(0, 32'h0);
  endtask

  task automatic t_out_modes;
    wr(2, 32'hFFFF_FFF0);
    wr(3, 32'hFFFF_FFF2);
    wr(1, 32'hFFFF_FFF0);
    wr(0, RUN | AR | CMP | tsel(2) | TOG);
    wait_n(2);
    chk("R10", "mode 2 toggles on match", 32'(pwm_out), 32'h1);
    wr(0, 32'h0);
    wr(1, 32'hFFFF_FFF0);
    wr(0, RUN | AR | CMP | tsel(1) | TOG);
    wait_n(2);
    chk("R10", "mode 1 ignores match", 32'(pwm_out), 32'h0);
    wr(0, 32'h0);
    wr(2, 32'hFFFF_FFFE);
    wr(1, 32'hFFFF_FFFE);
    wr(0, RUN | AR | tsel(0) | TOG);
    wait_n(2);
    chk("R10", "mode 0 overflow seen", 32'(evt_flags[1]), 32'h1);
    chk("R10", "mode 0 no toggle", 32'(pwm_out), 32'h0);
    wr(0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_start_and_hold;
    t_prescaler;
    t_wrap;
    t_reload;
    t_match;
    t_capture_single;
    t_capture_dual;
    t_out_toggle_ovf;
    t_out_pulse;
    t_out_modes;
    done = 1;
    report;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report;
    end
  end

endmodule